// File: doc/BRIEF.md
# GPIO controller with edge-event interrupts

A 32-pin general-purpose I/O peripheral reached through a simple word-wide register bus with separate read and write strobes. Software chooses for each pin whether it is an input or an output. An output pin is either push-pull or open-drain. An open-drain pin only ever pulls low and releases the line otherwise.

Every pin level is passed through a two-stage synchroniser. Input pins then feed an edge detector. The detector reacts either to both edges or to falling edges only, chosen per pin. Detected edges are held in a sticky event register until software clears them by writing ones. The pending events that software has enabled are ORed into a single interrupt line.

Registers are decoded on byte offsets with a stride of four. Pin n lives at register bit 31-n, so pin 0 is the most significant bit of every register. The pin-side ports are indexed by pin number.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: After reset all six registers read as zero, `pin_oe` is all zero and `irq` is low, so every pin is an input, every event is masked and both-edges mode is selected.
- R2: Registers sit at byte offsets 0x00 direction, 0x04 open-drain, 0x08 data, 0x0C event, 0x10 mask and 0x14 control. Pin n maps to register bit 31-n. A read strobe sampled on one clock edge presents the data on `bus_rdata` after that edge, and the data holds until the next read. Reads of any other offset return zero.
- R3: A direction bit of 1 makes the pin an output, and a 0 makes it an input with `pin_oe` low. A push-pull output (open-drain bit 0) drives `pin_oe`=1 with `pin_out` equal to its data bit.
- R4: An output whose open-drain bit is 1 drives `pin_oe`=1 and `pin_out`=0 when its data bit is 0. When its data bit is 1 it has `pin_oe`=0.
- R5: A data register read returns the stored data bit for output pins and the synchronised pin level for input pins. A data register write changes only the stored data bits.
- R6: With control bit 0, both a rising and a falling level change of an input pin set its event bit. The bit is set on the third clock edge after the pin change.
- R7: With control bit 1, only falling edges set the event bit, and rising edges are ignored.
- R8: Writing 1 to an event bit clears it, and writing 0 leaves it unchanged.
- R9: When a new edge and a clearing write hit the same event bit on the same clock edge, the bit stays set.
- R10: `irq` is high exactly when some event bit and its mask bit are both 1. It follows the registers with no extra delay.
- R11: Pins configured as outputs never set their event bits, whatever their pin level does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, one word per cycle |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | 32 | Pin levels, index = pin number |
| pin_out | output | 32 | Output level per pin |
| pin_oe | output | 32 | Output enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
Register writes show on `pin_oe`, `pin_out` and `irq` right after the clock edge that samples them. Read data appears after the edge that samples the read strobe. A pin change reaches the data register read path after two edges and sets its event bit, and so `irq`, on the third edge. The bench drives every input at the falling clock edge and compares a behavioural model one time unit after each rising edge. Its directed checks wait the exact number of falling edges listed above before sampling, and it lines up a clearing write with the third edge after a pin change to test the priority rule.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  typedef enum logic [2:0] {
    SEL_DIR,
    SEL_ODR,
    SEL_DAT,
    SEL_EVT,
    SEL_MSK,
    SEL_CTL,
    SEL_NONE
  } reg_sel_e;

  localparam int NUM_REGS = 6;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level_o = sync_q;
  assign rise_o  = sync_q & ~prev_q;
  assign fall_o  = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_evt_edge.sv
module gpio_evt_edge #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] fall_i,
  input  logic [N-1:0] fall_only_i,
  input  logic [N-1:0] is_input_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] event_o,
  output logic         irq_o
);
  logic [N-1:0] ev_q, set_v;

  function automatic logic [N-1:0] hits(input logic [N-1:0] r, input logic [N-1:0] f,
                                        input logic [N-1:0] fo, input logic [N-1:0] inp);
    return inp & (f | (r & ~fo));
  endfunction

  assign set_v = hits(rise_i, fall_i, fall_only_i, is_input_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= (ev_q & ~clr_i) | set_v;
  end

  assign event_o = ev_q;
  assign irq_o   = |(ev_q & mask_i);

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev_q & $past(set_v)) == $past(set_v))); // R9
  AST_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v & fall_only_i & ~fall_i) == '0); // R7
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i == '0 && set_v == '0) |=> $stable(ev_q)); // R8
  AST_OUT_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v & ~is_input_i) == '0); // R11
endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
#(
  parameter int NPIN   = 32,
  parameter int ADDR_W = 8,
  parameter int STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic              irq
);
  localparam int SPAN = NUM_REGS * STRIDE;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    if (int'(a) >= SPAN || (int'(a) % STRIDE) != 0) return SEL_NONE;
    case (int'(a) / STRIDE)
      0:       return SEL_DIR;
      1:       return SEL_ODR;
      2:       return SEL_DAT;
      3:       return SEL_EVT;
      4:       return SEL_MSK;
      default: return SEL_CTL;
    endcase
  endfunction

  reg_sel_e sel;
  logic [NPIN-1:0] dir_q, odr_q, dat_q, msk_q, ctl_q;
  logic [NPIN-1:0] pin_bus, lvl_b, rise_b, fall_b, evt_b, evt_clr;
  logic [NPIN-1:0] oe_b, out_b, rd_mux, rdata_q;

  assign sel = decode(bus_addr);

  // Pin n <-> register bit NPIN-1-n
  for (genvar n = 0; n < NPIN; n++) begin : g_map
    assign pin_bus[NPIN-1-n] = pin_in[n];
    assign pin_oe[n]         = oe_b[NPIN-1-n];
    assign pin_out[n]        = out_b[NPIN-1-n];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      odr_q <= '0;
      dat_q <= '0;
      msk_q <= '0;
      ctl_q <= '0;
    end else if (bus_wr_en) begin
      case (sel)
        SEL_DIR: dir_q <= bus_wdata;
        SEL_ODR: odr_q <= bus_wdata;
        SEL_DAT: dat_q <= bus_wdata;
        SEL_MSK: msk_q <= bus_wdata;
        SEL_CTL: ctl_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign evt_clr = (bus_wr_en && sel == SEL_EVT) ? bus_wdata : '0;

  gpio_in_sync #(.N(NPIN)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_bus),
    .level_o (lvl_b),
    .rise_o  (rise_b),
    .fall_o  (fall_b)
  );

  gpio_evt_edge #(.N(NPIN)) u_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise_i      (rise_b),
    .fall_i      (fall_b),
    .fall_only_i (ctl_q),
    .is_input_i  (~dir_q),
    .clr_i       (evt_clr),
    .mask_i      (msk_q),
    .event_o     (evt_b),
    .irq_o       (irq)
  );

  // Pad drive: open-drain outputs release the line when their data bit is 1
  assign oe_b  = dir_q & ~(odr_q & dat_q);
  assign out_b = dat_q & ~odr_q;

  always_comb begin
    case (sel)
      SEL_DIR: rd_mux = dir_q;
      SEL_ODR: rd_mux = odr_q;
      SEL_DAT: rd_mux = (dat_q & dir_q) | (lvl_b & ~dir_q);
      SEL_EVT: rd_mux = evt_b;
      SEL_MSK: rd_mux = msk_q;
      SEL_CTL: rd_mux = ctl_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata_q <= '0;
    else if (bus_rd_en) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_b & out_b & odr_q) == '0); // R4
  AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_b & ~dir_q) == '0); // R3
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && sel == SEL_NONE) |=> bus_rdata == '0); // R2
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |=> $stable(bus_rdata)); // R2
endmodule

// File: tb/gpio_evt_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_evt_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, pin_in = '0;
  logic [31:0] bus_rdata, pin_out, pin_oe;
  logic irq;
  int tests = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  gpio_evt_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // Behavioural model, arrays indexed by pin number
  logic [31:0] m_dir, m_odr, m_dat, m_evt, m_msk, m_ctl, m_s1, m_s2, m_pv, m_rd;

  function automatic logic [31:0] to_bus(input logic [31:0] p);
    logic [31:0] b;
    for (int n = 0; n < 32; n++) b[31-n] = p[n];
    return b;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      {m_dir, m_odr, m_dat, m_evt, m_msk, m_ctl, m_s1, m_s2, m_pv, m_rd} = '0;
    end else begin
      logic [31:0] nev;
      for (int n = 0; n < 32; n++) begin
        logic edge_seen, hit, clr;
        edge_seen = (m_s2[n] != m_pv[n]);
        hit = edge_seen && !m_dir[n] && (!m_ctl[n] || m_pv[n]);
        clr = bus_wr_en && bus_addr == 8'h0C && bus_wdata[31-n];
        nev[n] = hit ? 1'b1 : (clr ? 1'b0 : m_evt[n]);
      end
      if (bus_rd_en) begin
        case (bus_addr)
          8'h00: m_rd = to_bus(m_dir);
          8'h04: m_rd = to_bus(m_odr);
          8'h08: begin
            logic [31:0] v;
            for (int n = 0; n < 32; n++) v[n] = m_dir[n] ? m_dat[n] : m_s2[n];
            m_rd = to_bus(v);
          end
          8'h0C: m_rd = to_bus(m_evt);
          8'h10: m_rd = to_bus(m_msk);
          8'h14: m_rd = to_bus(m_ctl);
          default: m_rd = '0;
        endcase
      end
      if (bus_wr_en) begin
        case (bus_addr)
          8'h00: m_dir = to_bus(bus_wdata);
          8'h04: m_odr = to_bus(bus_wdata);
          8'h08: m_dat = to_bus(bus_wdata);
          8'h10: m_msk = to_bus(bus_wdata);
          8'h14: m_ctl = to_bus(bus_wdata);
          default: ;
        endcase
      end
      m_evt = nev;
      m_pv = m_s2;
      m_s2 = m_s1;
      m_s1 = pin_in;
    end
    if (cyc > 20000) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-cycle compare one time unit after the rising edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      logic [31:0] e_oe, e_out;
      for (int n = 0; n < 32; n++) begin
        e_oe[n]  = m_dir[n] && !(m_odr[n] && m_dat[n]);
        e_out[n] = m_dat[n] && !m_odr[n];
      end
      chk("R3 model pin_oe", pin_oe, e_oe);
      chk("R4 model pin_out", pin_out, e_out);
      chk("R10 model irq", {31'b0, irq}, {31'b0, |(m_evt & m_msk)});
      chk("R5 model rdata", bus_rdata, m_rd);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle3();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] r;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    for (int a = 0; a < 24; a += 4) begin
      rd(8'(a), r);
      chk("R1 reg zero", r, 32'h0);
    end
    // R3 push-pull output on pin 0 (bit 31)
    wr(8'h00, 32'h8000_0000);
    wr(8'h08, 32'h8000_0000);
    chk("R3 pin_oe pin0", pin_oe, 32'h1);
    chk("R3 pin_out pin0", pin_out, 32'h1);
    // R2 readback, ordering, unmapped
    rd(8'h00, r); chk("R2 dir readback", r, 32'h8000_0000);
    rd(8'h18, r); chk("R2 unmapped 0x18", r, 32'h0);
    rd(8'h41, r); chk("R2 unmapped 0x41", r, 32'h0);
    // R4 open drain
    wr(8'h04, 32'h8000_0000);
    chk("R4 od release", pin_oe, 32'h0);
    wr(8'h08, 32'h0);
    chk("R4 od drive oe", pin_oe, 32'h1);
    chk("R4 od drive low", pin_out, 32'h0);
    wr(8'h04, 32'h0);
    // R5/R11: pin5 rises (input), pin0 toggles as output
    pin_in[5] = 1'b1; pin_in[0] = 1'b1;
    repeat (2) @(negedge clk);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, r); chk("R5 data read mix", r, 32'h8400_0000);
    wr(8'h08, 32'h0);
    rd(8'h0C, r); chk("R6 rise event, R11 no output event", r, 32'h0400_0000);
    wr(8'h0C, 32'h0);
    rd(8'h0C, r); chk("R8 write zero keeps", r, 32'h0400_0000);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, r); chk("R8 write one clears", r, 32'h0);
    // R10 mask and falling edge in both-edges mode
    wr(8'h10, 32'h0400_0000);
    pin_in[5] = 1'b0;
    settle3();
    chk("R6 fall sets irq", {31'b0, irq}, 32'h1);
    wr(8'h10, 32'h0);
    chk("R10 masked irq low", {31'b0, irq}, 32'h0);
    wr(8'h10, 32'h0400_0000);
    wr(8'h0C, 32'h0400_0000);
    chk("R8 cleared irq low", {31'b0, irq}, 32'h0);
    // R7 falling only
    wr(8'h14, 32'h0400_0000);
    pin_in[5] = 1'b1;
    settle3(); @(negedge clk);
    rd(8'h0C, r); chk("R7 rise ignored", r, 32'h0);
    pin_in[5] = 1'b0;
    settle3();
    rd(8'h0C, r); chk("R7 fall recorded", r, 32'h0400_0000);
    // R9 edge wins over clear on the same edge
    wr(8'h14, 32'h0);
    pin_in[5] = 1'b1;
    repeat (2) @(negedge clk);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, r); chk("R9 edge beats clear", r, 32'h0400_0000);
    wr(8'h0C, 32'hFFFF_FFFF);
    // R2/R6 far end: pin 31 is bit 0
    pin_in[31] = 1'b1;
    settle3();
    rd(8'h0C, r); chk("R2 pin31 event bit0", r, 32'h0000_0001);
    // R11 output pin toggle after clear
    wr(8'h0C, 32'hFFFF_FFFF);
    pin_in[0] = 1'b0;
    settle3(); @(negedge clk);
    rd(8'h0C, r); chk("R11 output pin no event", r, 32'h0);
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule